// File: doc/BRIEF.md
# Prioritized Exception Vector Controller

This block sits next to a CPU core and decides which exception request gets serviced next. Three kinds of reset, an illegal-opcode trap, a software-interrupt/debug request, one X-maskable interrupt and a parameterized set of 2 to 122 I-maskable interrupts compete. On every clock the block computes the winner, registers its 16-bit vector address, and presents that address on `vec_addr` while the CPU pulses `vec_fetch`. It also signals the CPU that a maskable interrupt is waiting, and raises a wake-up output in low-power modes.

The I and X interrupts are qualified by the CPU's mask bits and by separate inhibit inputs. The CPU can write a small register that promotes one I source above all other I sources. The wake path is purely combinational, so it works with the clock stopped. No streaming data crosses this block. `vec_fetch`, `prio_wr` and all request lines are plain level or strobe controls with no valid/ready handshake, so there is no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `vec_addr` is 0x0000, `irq_pending` and `wake` are low, a fetch with no request pending returns 0xFFFE, and no I source is promoted (source 0 already ranks highest).
- R2: `vec_addr` is 0x0000 in every cycle where `vec_fetch` is low.
- R3: Resets rank above every other source: external reset gives 0xFFFE, clock-monitor reset gives 0xFFFC and watchdog reset gives 0xFFFA, in that order of precedence.
- R4: The illegal-opcode trap (0xFFF8) outranks the software interrupt, X and all I requests.
- R5: The software/debug request (0xFFF6) outranks X and all I requests.
- R6: An unmasked, uninhibited X request (0xFFF4) outranks all I requests.
- R7: I source k uses vector 0xFFF2 − 2·k. Without promotion, a lower k (a higher address) wins.
- R8: I requests take no part in arbitration while `cpu_imask` or `inh_i` is high. X takes no part while `cpu_xmask` or `inh_x` is high.
- R9: Writing a valid vector low byte B through `prio_wr`/`prio_wdata` promotes source (0xF2 − B)/2 above all other I sources. The write takes effect at the next clock edge.
- R10: A write whose byte is odd, above 0xF2, or below 0xF2 − 2·(NUM_I−1) is ignored, and the previous promotion stays in force.
- R11: `irq_pending` is high exactly when an eligible I or X request exists under the masks and inhibits of R8.
- R12: `wake` is high only while `low_power` is high. It is then driven combinationally by any eligible I request, and by `xirq_req` regardless of `cpu_xmask` and `inh_x`.
- R13: The vector shown during a fetch is the winner registered at the last clock edge that was not inside a fetch. When no source wins, the registered vector keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_ext_req | input | 1 | External/power-on reset request |
| rst_clkmon_req | input | 1 | Clock-monitor reset request |
| rst_wdog_req | input | 1 | Watchdog reset request |
| trap_req | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software interrupt or debug request |
| xirq_req | input | 1 | X-maskable interrupt request |
| irq_req | input | NUM_I | I-maskable interrupt requests, bit k is source k |
| cpu_imask | input | 1 | CPU I mask bit |
| cpu_xmask | input | 1 | CPU X mask bit |
| inh_i | input | 1 | Inhibit for I requests |
| inh_x | input | 1 | Inhibit for X request |
| low_power | input | 1 | CPU is in stop or wait mode |
| prio_wr | input | 1 | Promotion register write strobe |
| prio_wdata | input | 8 | Vector low byte of the I source to promote |
| vec_fetch | input | 1 | Vector fetch strobe from the CPU |
| vec_addr | output | 16 | Vector address, valid during `vec_fetch` |
| irq_pending | output | 1 | A maskable interrupt is eligible |
| wake | output | 1 | Wake-up request in low-power mode |

## Verification
The bound checker watches on every cycle that the address bus is quiet outside fetches, that any fetched vector lies in the top page at an even address, that a fetch is stable while the strobe stays high, that an external reset request always fetches 0xFFFE, and the implications tying `irq_pending` and `wake` to masks, inhibits and low-power mode. Only the directed scenarios can show the full ranking among simultaneous requests, the exact per-source I vectors, the effect of promotion and the rejection of bad writes, and the held vector when everything is masked. These depend on particular request mixes and write sequences that no per-cycle property covers.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam logic [15:0] VEC_RST_EXT    = 16'hFFFE;
  localparam logic [15:0] VEC_RST_CLKMON = 16'hFFFC;
  localparam logic [15:0] VEC_RST_WDOG   = 16'hFFFA;
  localparam logic [15:0] VEC_TRAP       = 16'hFFF8;
  localparam logic [15:0] VEC_SWI        = 16'hFFF6;
  localparam logic [15:0] VEC_XIRQ       = 16'hFFF4;
  localparam logic [15:0] VEC_I_TOP      = 16'hFFF2;
  localparam logic [7:0]  I_TOP_LOW      = 8'hF2;
  localparam int          MAX_I_SRC      = 122;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_RST_EXT,
    WIN_RST_CLKMON,
    WIN_RST_WDOG,
    WIN_TRAP,
    WIN_SWI,
    WIN_XIRQ,
    WIN_IRQ
  } win_kind_e;

  typedef struct packed {
    logic        valid;
    win_kind_e   kind;
    logic [15:0] vec;
  } win_t;

endpackage

// File: rtl/ivc_prio_reg.sv
module ivc_prio_reg #(
  parameter int NUM_I = 8,
  parameter int IDXW  = (NUM_I > 1) ? $clog2(NUM_I) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_byte,
  output logic [IDXW-1:0] prom_idx
);
  import ivc_pkg::*;

  localparam logic [7:0] LOW_MIN = 8'(242 - 2 * (NUM_I - 1));

  logic       byte_ok;
  logic [7:0] byte_dist;

  // A byte is accepted only if it names an implemented I vector.
  always_comb begin
    byte_dist = I_TOP_LOW - wr_byte;
    byte_ok   = !wr_byte[0] && (wr_byte <= I_TOP_LOW) && (wr_byte >= LOW_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prom_idx <= '0;
    end else if (wr_en && byte_ok) begin
      prom_idx <= IDXW'(byte_dist[7:1]);
    end
  end

endmodule

// File: rtl/ivc_isel.sv
module ivc_isel #(
  parameter int NUM_I = 8,
  parameter int IDXW  = (NUM_I > 1) ? $clog2(NUM_I) : 1
) (
  input  logic [NUM_I-1:0] irq_req,
  input  logic             i_block,
  input  logic [IDXW-1:0]  prom_idx,
  output logic [NUM_I-1:0] i_elig,
  output logic             i_any,
  output logic [IDXW-1:0]  win_idx
);

  // Qualify each source with the shared I mask/inhibit.
  for (genvar g = 0; g < NUM_I; g++) begin : g_elig
    assign i_elig[g] = irq_req[g] & ~i_block;
  end

  assign i_any = |i_elig;

  // Fixed order: lowest index wins; promoted source overrides.
  always_comb begin
    win_idx = '0;
    for (int k = NUM_I - 1; k >= 0; k--) begin
      if (i_elig[k]) win_idx = IDXW'(k);
    end
    if (i_elig[prom_idx]) win_idx = prom_idx;
  end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            rst_ext_req,
  input  logic            rst_clkmon_req,
  input  logic            rst_wdog_req,
  input  logic            trap_req,
  input  logic            swi_req,
  input  logic            x_elig,
  input  logic            i_any,
  input  logic [IDXW-1:0] i_win_idx,
  output win_t            win
);

  logic [15:0] i_vec;

  assign i_vec = VEC_I_TOP - {15'(i_win_idx), 1'b0};

  always_comb begin
    win = '{valid: 1'b1, kind: WIN_NONE, vec: VEC_RST_EXT};
    if (rst_ext_req) begin
      win.kind = WIN_RST_EXT;
      win.vec  = VEC_RST_EXT;
    end else if (rst_clkmon_req) begin
      win.kind = WIN_RST_CLKMON;
      win.vec  = VEC_RST_CLKMON;
    end else if (rst_wdog_req) begin
      win.kind = WIN_RST_WDOG;
      win.vec  = VEC_RST_WDOG;
    end else if (trap_req) begin
      win.kind = WIN_TRAP;
      win.vec  = VEC_TRAP;
    end else if (swi_req) begin
      win.kind = WIN_SWI;
      win.vec  = VEC_SWI;
    end else if (x_elig) begin
      win.kind = WIN_XIRQ;
      win.vec  = VEC_XIRQ;
    end else if (i_any) begin
      win.kind = WIN_IRQ;
      win.vec  = i_vec;
    end else begin
      win.valid = 1'b0;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_I = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_ext_req,
  input  logic             rst_clkmon_req,
  input  logic             rst_wdog_req,
  input  logic             trap_req,
  input  logic             swi_req,
  input  logic             xirq_req,
  input  logic [NUM_I-1:0] irq_req,
  input  logic             cpu_imask,
  input  logic             cpu_xmask,
  input  logic             inh_i,
  input  logic             inh_x,
  input  logic             low_power,
  input  logic             prio_wr,
  input  logic [7:0]       prio_wdata,
  input  logic             vec_fetch,
  output logic [15:0]      vec_addr,
  output logic             irq_pending,
  output logic             wake
);

  localparam int IDXW = (NUM_I > 1) ? $clog2(NUM_I) : 1;

  logic [IDXW-1:0]  prom_idx;
  logic [IDXW-1:0]  i_win_idx;
  logic [NUM_I-1:0] i_elig;
  logic             i_any;
  logic             x_elig;
  win_t             win;
  logic [15:0]      held_vec;

  ivc_prio_reg #(.NUM_I(NUM_I), .IDXW(IDXW)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (prio_wr),
    .wr_byte  (prio_wdata),
    .prom_idx (prom_idx)
  );

  ivc_isel #(.NUM_I(NUM_I), .IDXW(IDXW)) u_isel (
    .irq_req  (irq_req),
    .i_block  (cpu_imask | inh_i),
    .prom_idx (prom_idx),
    .i_elig   (i_elig),
    .i_any    (i_any),
    .win_idx  (i_win_idx)
  );

  assign x_elig = xirq_req & ~cpu_xmask & ~inh_x;

  ivc_arbiter #(.IDXW(IDXW)) u_arb (
    .rst_ext_req    (rst_ext_req),
    .rst_clkmon_req (rst_clkmon_req),
    .rst_wdog_req   (rst_wdog_req),
    .trap_req       (trap_req),
    .swi_req        (swi_req),
    .x_elig         (x_elig),
    .i_any          (i_any),
    .i_win_idx      (i_win_idx),
    .win            (win)
  );

  // Winner is captured outside fetches and frozen while the CPU reads it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vec <= VEC_RST_EXT;
    end else if (!vec_fetch && win.valid) begin
      held_vec <= win.vec;
    end
  end

  assign vec_addr    = vec_fetch ? held_vec : 16'h0000;
  assign irq_pending = i_any | x_elig;
  // Clock-free wake: X wakes even when masked or inhibited.
  assign wake        = low_power & (i_any | xirq_req);

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_I = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ext_req,
  input logic             xirq_req,
  input logic [NUM_I-1:0] irq_req,
  input logic             cpu_imask,
  input logic             cpu_xmask,
  input logic             inh_i,
  input logic             inh_x,
  input logic             low_power,
  input logic             vec_fetch,
  input logic [15:0]      vec_addr,
  input logic             irq_pending,
  input logic             wake
);

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_fetch |-> vec_addr == 16'h0000);

  a_r7_vector_in_top_page: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> (vec_addr[15:8] == 8'hFF && !vec_addr[0]));

  a_r3_ext_reset_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ext_req && !vec_fetch) |=> (!vec_fetch || vec_addr == 16'hFFFE));

  a_r13_fetch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && $past(vec_fetch)) |-> $stable(vec_addr));

  a_r11_pending_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (|irq_req || xirq_req));

  a_r8_all_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_imask || inh_i) && (cpu_xmask || inh_x)) |-> !irq_pending);

  a_r12_wake_on_masked_x: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && xirq_req) |-> wake);

  a_r12_no_wake_when_run: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |-> !wake);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_I(NUM_I)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_ext_req (rst_ext_req),
  .xirq_req    (xirq_req),
  .irq_req     (irq_req),
  .cpu_imask   (cpu_imask),
  .cpu_xmask   (cpu_xmask),
  .inh_i       (inh_i),
  .inh_x       (inh_x),
  .low_power   (low_power),
  .vec_fetch   (vec_fetch),
  .vec_addr    (vec_addr),
  .irq_pending (irq_pending),
  .wake        (wake)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  localparam int NUM_I = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rst_ext_req = 1'b0, rst_clkmon_req = 1'b0, rst_wdog_req = 1'b0;
  logic             trap_req = 1'b0, swi_req = 1'b0, xirq_req = 1'b0;
  logic [NUM_I-1:0] irq_req = '0;
  logic             cpu_imask = 1'b0, cpu_xmask = 1'b0, inh_i = 1'b0, inh_x = 1'b0;
  logic             low_power = 1'b0;
  logic             prio_wr = 1'b0;
  logic [7:0]       prio_wdata = 8'h00;
  logic             vec_fetch = 1'b0;
  logic [15:0]      vec_addr;
  logic             irq_pending;
  logic             wake;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_I(NUM_I)) u_irq_vector_ctrl (
    .clk, .rst_n, .rst_ext_req, .rst_clkmon_req, .rst_wdog_req,
    .trap_req, .swi_req, .xirq_req, .irq_req,
    .cpu_imask, .cpu_xmask, .inh_i, .inh_x, .low_power,
    .prio_wr, .prio_wdata, .vec_fetch, .vec_addr, .irq_pending, .wake
  );

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    rst_ext_req = 0; rst_clkmon_req = 0; rst_wdog_req = 0;
    trap_req = 0; swi_req = 0; xirq_req = 0; irq_req = '0;
    cpu_imask = 0; cpu_xmask = 0; inh_i = 0; inh_x = 0; low_power = 0;
  endtask

  // Inputs already set at a negedge; one edge latches, then fetch.
  task automatic fetch_expect(input logic [15:0] exp, input string req);
    @(posedge clk);
    @(negedge clk);
    vec_fetch = 1'b1;
    #1;
    check16(vec_addr, exp, req);
    @(negedge clk);
    vec_fetch = 1'b0;
  endtask

  task automatic write_prio(input logic [7:0] b);
    @(negedge clk);
    prio_wr = 1'b1; prio_wdata = b;
    @(negedge clk);
    prio_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    #1;
    check16(vec_addr, 16'h0000, "R1 bus after reset");
    check1(irq_pending, 1'b0, "R1 pending after reset");
    check1(wake, 1'b0, "R1 wake after reset");
    fetch_expect(16'hFFFE, "R1 fetch with nothing pending");
    #1;
    check16(vec_addr, 16'h0000, "R2 bus idle between fetches");
  endtask

  task automatic t_resets();
    idle_inputs();
    rst_ext_req = 1; rst_clkmon_req = 1; rst_wdog_req = 1; trap_req = 1; xirq_req = 1; irq_req = 8'hFF;
    fetch_expect(16'hFFFE, "R3 external reset wins");
    idle_inputs();
    rst_clkmon_req = 1; rst_wdog_req = 1; swi_req = 1;
    fetch_expect(16'hFFFC, "R3 clock monitor over watchdog");
    idle_inputs();
    rst_wdog_req = 1; trap_req = 1;
    fetch_expect(16'hFFFA, "R3 watchdog over trap");
  endtask

  task automatic t_fixed_chain();
    idle_inputs();
    trap_req = 1; swi_req = 1; xirq_req = 1; irq_req = 8'h01;
    fetch_expect(16'hFFF8, "R4 trap over swi/x/i");
    idle_inputs();
    swi_req = 1; xirq_req = 1; irq_req = 8'h01;
    fetch_expect(16'hFFF6, "R5 swi over x/i");
    idle_inputs();
    xirq_req = 1; irq_req = 8'h01;
    fetch_expect(16'hFFF4, "R6 x over i");
  endtask

  task automatic t_i_order();
    idle_inputs();
    irq_req = 8'b1010_0100;
    fetch_expect(16'hFFEE, "R7 lowest index of 2,5,7");
    idle_inputs();
    irq_req = 8'h80;
    fetch_expect(16'hFFE4, "R7 last source vector");
  endtask

  task automatic t_masking();
    idle_inputs();
    xirq_req = 1; cpu_xmask = 1; irq_req = 8'h02;
    fetch_expect(16'hFFF0, "R8 masked x loses to i");
    #1;
    check1(irq_pending, 1'b1, "R11 pending with eligible i");
    @(negedge clk);
    cpu_imask = 1;
    #1;
    check1(irq_pending, 1'b0, "R11 no pending all masked");
    fetch_expect(16'hFFF0, "R13 held vector when nothing eligible");
    idle_inputs();
    irq_req = 8'h01; inh_i = 1;
    #1;
    check1(irq_pending, 1'b0, "R8 inh_i blocks i");
    @(negedge clk);
    irq_req = '0; xirq_req = 1; inh_x = 1;
    #1;
    check1(irq_pending, 1'b0, "R8 inh_x blocks x");
    @(negedge clk);
    inh_x = 0;
    #1;
    check1(irq_pending, 1'b1, "R11 pending with eligible x");
  endtask

  task automatic t_promotion();
    idle_inputs();
    write_prio(8'hE8);
    irq_req = 8'h21;
    fetch_expect(16'hFFE8, "R9 promoted source 5 over source 0");
    write_prio(8'hE9);
    fetch_expect(16'hFFE8, "R10 odd byte ignored");
    write_prio(8'hE2);
    fetch_expect(16'hFFE8, "R10 byte below range ignored");
    write_prio(8'hF4);
    fetch_expect(16'hFFE8, "R10 byte above range ignored");
    @(negedge clk);
    irq_req = 8'h0A;
    fetch_expect(16'hFFF0, "R9 promoted source idle, normal order");
    write_prio(8'hF2);
    irq_req = 8'h21;
    fetch_expect(16'hFFF2, "R9 promotion returned to source 0");
  endtask

  task automatic t_wake();
    idle_inputs();
    low_power = 1; cpu_xmask = 1; xirq_req = 1;
    #1;
    check1(wake, 1'b1, "R12 masked x wakes");
    @(negedge clk);
    xirq_req = 0; cpu_imask = 1; irq_req = 8'h04;
    #1;
    check1(wake, 1'b0, "R12 masked i no wake");
    @(negedge clk);
    cpu_imask = 0;
    #1;
    check1(wake, 1'b1, "R12 enabled i wakes");
    @(negedge clk);
    low_power = 0; xirq_req = 1;
    #1;
    check1(wake, 1'b0, "R12 no wake when running");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_resets();
    t_fixed_chain();
    t_i_order();
    t_masking();
    t_promotion();
    t_wake();
    idle_inputs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected finished run");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule